// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the execute-stage arithmetic and logic unit of a small 32-bit load/store processor. On each cycle where an operation is presented, it combines a first operand, a second operand and a 16-bit immediate as the operation code selects. It registers a result together with a one-cycle write-enable pulse. It keeps a 4-bit condition register and raises a one-cycle exception pulse when a writing add or subtract overflows in two's complement.

The branch logic sits outside this block. It reads the zero flag and, after taking a zero-conditional jump, pulses a clear request so that the zero flag drops. Register file access, forwarding and pipelining are done elsewhere. The block only computes and keeps the flags.

All outputs come from registers. The asynchronous active-low reset is released to the internal flops through a two-stage synchronizer. Operations are therefore accepted from the third rising edge after `rst_n` goes high.

Top module: `alu_flagged`

## Requirements
- R1: During reset and until the first accepted operation, `result_o` is 0, `flags_o` is 0, and `wr_en_o` and `ovf_exc_o` are low.
- R2: Outputs are registered. An operation sampled with `op_valid_i` high at a rising edge shows its effect right after that edge. `wr_en_o` and `ovf_exc_o` are pulses one cycle long. When `op_valid_i` is low, both pulses are low and `result_o` holds its value.
- R3: Opcode 1 (add) returns a+b and opcode 3 (subtract) returns a-b, both modulo 2^32, with a write pulse.
- R4: Opcode 2 (add-immediate) and opcode 4 (subtract-immediate) use the 16-bit immediate as the second operand, sign-extended from its bit 15 to 32 bits.
- R5: Opcode 9 (load-immediate) returns the immediate in bits 15:0 with bits 31:16 zero. It writes and leaves the flags unchanged.
- R6: Opcodes 5, 6 and 7 return a AND b, a OR b and a XOR b. They write and clear the carry (bit 2) and overflow (bit 3) flags.
- R7: For opcodes 1 to 8, zero (flags bit 0) is set when the 32-bit result is all zeros, and negative (flags bit 1) copies result bit 31.
- R8: Carry (flags bit 2) is the carry out of bit 31 for opcodes 1 and 2. It is the unsigned borrow (first operand below second) for opcodes 3, 4 and 8.
- R9: Overflow (flags bit 3) flags signed overflow for opcodes 1 to 4 and 8. `ovf_exc_o` pulses only for overflowing opcodes 1 to 4, never for compare.
- R10: Opcode 8 (compare) computes a-b for the flags only. It gives no write pulse and leaves `result_o` unchanged.
- R11: Opcode 0 (move) returns the first operand with a write pulse and leaves all four flags unchanged.
- R12: `zclr_i` high at an edge clears only the zero flag, whatever the state of `op_valid_i`. When an accepted operation at the same edge updates zero, the operation's value wins.
- R13: Opcodes 10 to 15 write nothing, raise no exception, and leave the result and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Operation present this cycle |
| op_code_i | input | 4 | Operation code |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| imm_i | input | 16 | Immediate field |
| zclr_i | input | 1 | Zero-flag clear request from branch logic |
| result_o | output | 32 | Registered result |
| wr_en_o | output | 1 | Result write pulse |
| flags_o | output | 4 | {overflow, carry, negative, zero} |
| ovf_exc_o | output | 1 | Signed-overflow exception pulse |

## Verification
Random operands are drawn half the time from a corner pool of 0, 1, all-ones, the two signed extremes and 0x8000-style immediates. This drives the carry, borrow and overflow logic across every boundary where the add and subtract paths diverge. Directed vectors set operands equal for compare, put immediates with bit 15 both set and clear to tell sign from zero extension, and issue move and load-immediate after flag-setting operations to show the flags are held. Clear requests, idle cycles and unused opcodes are mixed with valid operations, both alone and on the same edge. This separates clear priority from plain hold behaviour.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  typedef enum logic [3:0] {
    OP_MOV  = 4'd0,
    OP_ADD  = 4'd1,
    OP_ADDI = 4'd2,
    OP_SUB  = 4'd3,
    OP_SUBI = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_CMP  = 4'd8,
    OP_LDI  = 4'd9
  } alu_op_e;

  typedef enum logic [2:0] {
    RS_PASS = 3'd0,
    RS_ARTH = 3'd1,
    RS_AND  = 3'd2,
    RS_OR   = 3'd3,
    RS_XOR  = 3'd4,
    RS_IMMZ = 3'd5
  } res_sel_e;

  typedef struct packed {
    logic     writes;
    logic     upd_zn;
    logic     upd_cv;
    logic     clr_cv;
    logic     use_imm;
    logic     do_sub;
    logic     trap;
    res_sel_e sel;
  } alu_ctl_t;

  function automatic alu_ctl_t alu_decode(input logic [3:0] code);
    alu_ctl_t c;
    c = '{writes: 1'b0, upd_zn: 1'b0, upd_cv: 1'b0, clr_cv: 1'b0,
          use_imm: 1'b0, do_sub: 1'b0, trap: 1'b0, sel: RS_PASS};
    case (code)
      OP_MOV:  c.writes = 1'b1;
      OP_ADD:  begin c.writes = 1'b1; c.upd_zn = 1'b1; c.upd_cv = 1'b1; c.trap = 1'b1; c.sel = RS_ARTH; end
      OP_ADDI: begin c.writes = 1'b1; c.upd_zn = 1'b1; c.upd_cv = 1'b1; c.trap = 1'b1; c.use_imm = 1'b1; c.sel = RS_ARTH; end
      OP_SUB:  begin c.writes = 1'b1; c.upd_zn = 1'b1; c.upd_cv = 1'b1; c.trap = 1'b1; c.do_sub = 1'b1; c.sel = RS_ARTH; end
      OP_SUBI: begin c.writes = 1'b1; c.upd_zn = 1'b1; c.upd_cv = 1'b1; c.trap = 1'b1; c.do_sub = 1'b1; c.use_imm = 1'b1; c.sel = RS_ARTH; end
      OP_AND:  begin c.writes = 1'b1; c.upd_zn = 1'b1; c.clr_cv = 1'b1; c.sel = RS_AND; end
      OP_OR:   begin c.writes = 1'b1; c.upd_zn = 1'b1; c.clr_cv = 1'b1; c.sel = RS_OR; end
      OP_XOR:  begin c.writes = 1'b1; c.upd_zn = 1'b1; c.clr_cv = 1'b1; c.sel = RS_XOR; end
      OP_CMP:  begin c.upd_zn = 1'b1; c.upd_cv = 1'b1; c.do_sub = 1'b1; c.sel = RS_ARTH; end
      OP_LDI:  begin c.writes = 1'b1; c.sel = RS_IMMZ; end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/alu_opnd_ext.sv
module alu_opnd_ext #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] opb_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  output logic [DATA_W-1:0] b_eff_o,
  output logic [DATA_W-1:0] imm_zext_o
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_sext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_sext   = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
      assign imm_zext_o = {{EXT_W{1'b0}}, imm_i};
    end else begin : g_trunc
      assign imm_sext   = imm_i[DATA_W-1:0];
      assign imm_zext_o = imm_i[DATA_W-1:0];
    end
  endgenerate

  assign b_eff_o = use_imm_i ? imm_sext : opb_i;

endmodule

// File: rtl/alu_arith_core.sv
module alu_arith_core
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] immz_i,
  input  logic              do_sub_i,
  input  res_sel_e          sel_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              ovf_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0]   wide;
  logic [DATA_W-1:0] arith;

  always_comb begin
    if (do_sub_i) wide = {1'b0, a_i} - {1'b0, b_i};
    else          wide = {1'b0, a_i} + {1'b0, b_i};
  end

  assign arith   = wide[DATA_W-1:0];
  assign carry_o = wide[DATA_W];

  always_comb begin
    if (do_sub_i) ovf_o = (a_i[MSB] != b_i[MSB]) && (arith[MSB] != a_i[MSB]);
    else          ovf_o = (a_i[MSB] == b_i[MSB]) && (arith[MSB] != a_i[MSB]);
  end

  always_comb begin
    case (sel_i)
      RS_ARTH: res_o = arith;
      RS_AND:  res_o = a_i & b_i;
      RS_OR:   res_o = a_i | b_i;
      RS_XOR:  res_o = a_i ^ b_i;
      RS_IMMZ: res_o = immz_i;
      default: res_o = a_i;
    endcase
  end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zn_en_i,
  input  logic              cv_en_i,
  input  logic              cv_clr_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              carry_i,
  input  logic              ovf_i,
  input  logic              zclr_i,
  output logic [3:0]        flags_o
);
  logic [3:0] flags_q, flags_d;

  always_comb begin
    flags_d = flags_q;
    if (zn_en_i) begin
      flags_d[0] = (res_i == '0);
      flags_d[1] = res_i[DATA_W-1];
    end else if (zclr_i) begin
      flags_d[0] = 1'b0;
    end
    if (cv_en_i) begin
      flags_d[2] = carry_i;
      flags_d[3] = ovf_i;
    end else if (cv_clr_i) begin
      flags_d[3:2] = 2'b00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  AST_ZCLR_ONLY_Z: assert property (@(posedge clk) disable iff (!rst_n)
    (zclr_i && !zn_en_i && !cv_en_i && !cv_clr_i) |=> (!flags_q[0] && flags_q[3:1] == $past(flags_q[3:1]))); // R12

  AST_CV_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_clr_i && !cv_en_i) |=> (flags_q[3:2] == 2'b00)); // R6

endmodule

// File: rtl/alu_flagged.sv
module alu_flagged
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int OPC_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid_i,
  input  logic [OPC_W-1:0]  op_code_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              zclr_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [3:0]        flags_o,
  output logic              ovf_exc_o
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_N-1];

  alu_ctl_t          ctl;
  logic [DATA_W-1:0] b_eff, immz, res;
  logic              carry, ovf;

  assign ctl = alu_decode(op_code_i);

  alu_opnd_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
    .opb_i      (opb_i),
    .imm_i      (imm_i),
    .use_imm_i  (ctl.use_imm),
    .b_eff_o    (b_eff),
    .imm_zext_o (immz)
  );

  alu_arith_core #(.DATA_W(DATA_W)) u_core (
    .a_i      (opa_i),
    .b_i      (b_eff),
    .immz_i   (immz),
    .do_sub_i (ctl.do_sub),
    .sel_i    (ctl.sel),
    .res_o    (res),
    .carry_o  (carry),
    .ovf_o    (ovf)
  );

  alu_flag_reg #(.DATA_W(DATA_W)) u_flags (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .zn_en_i  (op_valid_i && ctl.upd_zn),
    .cv_en_i  (op_valid_i && ctl.upd_cv),
    .cv_clr_i (op_valid_i && ctl.clr_cv),
    .res_i    (res),
    .carry_i  (carry),
    .ovf_i    (ovf),
    .zclr_i   (zclr_i),
    .flags_o  (flags_o)
  );

  logic [DATA_W-1:0] res_q, res_d;
  logic              we_q, we_d, exc_q, exc_d;

  always_comb begin
    we_d  = op_valid_i && ctl.writes;
    exc_d = op_valid_i && ctl.trap && ovf;
    res_d = we_d ? res : res_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_q <= '0;
      we_q  <= 1'b0;
      exc_q <= 1'b0;
    end else begin
      res_q <= res_d;
      we_q  <= we_d;
      exc_q <= exc_d;
    end
  end

  assign result_o  = res_q;
  assign wr_en_o   = we_q;
  assign ovf_exc_o = exc_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    !op_valid_i |=> (!wr_en_o && !ovf_exc_o && $stable(result_o))); // R2

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid_i && op_code_i == OP_CMP) |=> (!wr_en_o && !ovf_exc_o && $stable(result_o))); // R10

  AST_MOV_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid_i && op_code_i == OP_MOV && !zclr_i) |=> $stable(flags_o)); // R11

  AST_EXC_IMPLIES_OVF: assert property (@(posedge clk) disable iff (!rst_int_n)
    ovf_exc_o |-> (wr_en_o && flags_o[3])); // R9

  AST_UNUSED_INERT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid_i && op_code_i > OP_LDI && !zclr_i) |=> (!wr_en_o && $stable(flags_o) && $stable(result_o))); // R13

endmodule

// File: tb/alu_flagged_tb.sv
module alu_flagged_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SEED       = 32'h5a17;
  localparam int N_RAND     = 3000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid_i;
  logic [3:0]  op_code_i;
  logic [31:0] opa_i, opb_i;
  logic [15:0] imm_i;
  logic        zclr_i;
  logic [31:0] result_o;
  logic        wr_en_o;
  logic [3:0]  flags_o;
  logic        ovf_exc_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] e_res;
  logic        e_we, e_exc;
  logic [3:0]  e_flg;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_flagged u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_code_i(op_code_i),
    .opa_i(opa_i), .opb_i(opb_i), .imm_i(imm_i), .zclr_i(zclr_i),
    .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o), .ovf_exc_o(ovf_exc_o)
  );

  function automatic string tag_of(input logic v, input logic [3:0] op, input logic zc);
    if (!v) return zc ? "R12" : "R2";
    case (op)
      4'd0: return "R11";
      4'd1, 4'd3: return "R3/R7/R8/R9";
      4'd2, 4'd4: return "R4/R8/R9";
      4'd5, 4'd6, 4'd7: return "R6/R7";
      4'd8: return "R10/R8";
      4'd9: return "R5";
      default: return "R13";
    endcase
  endfunction

  task automatic model(input logic v, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] imm, input logic zc);
    logic [31:0] bx, r;
    logic [32:0] w;
    logic wr, zn, cv, clr, trp, sub, vv;
    bx = (op == 4'd2 || op == 4'd4) ? {{16{imm[15]}}, imm} : b;
    sub = (op == 4'd3 || op == 4'd4 || op == 4'd8);
    w = sub ? ({1'b0, a} - {1'b0, bx}) : ({1'b0, a} + {1'b0, bx});
    vv = sub ? (a[31] != bx[31] && w[31] != a[31]) : (a[31] == bx[31] && w[31] != a[31]);
    r = a; wr = 0; zn = 0; cv = 0; clr = 0; trp = 0;
    case (op)
      4'd0: wr = 1;
      4'd1, 4'd2, 4'd3, 4'd4: begin r = w[31:0]; wr = 1; zn = 1; cv = 1; trp = 1; end
      4'd5: begin r = a & b; wr = 1; zn = 1; clr = 1; end
      4'd6: begin r = a | b; wr = 1; zn = 1; clr = 1; end
      4'd7: begin r = a ^ b; wr = 1; zn = 1; clr = 1; end
      4'd8: begin r = w[31:0]; zn = 1; cv = 1; end
      4'd9: begin r = {16'h0, imm}; wr = 1; end
      default: ;
    endcase
    if (!v) begin wr = 0; zn = 0; cv = 0; clr = 0; trp = 0; end
    if (wr) e_res = r;
    e_we  = wr;
    e_exc = trp && vv;
    if (zn) begin e_flg[0] = (r == 32'h0); e_flg[1] = r[31]; end
    else if (zc) e_flg[0] = 1'b0;
    if (cv) begin e_flg[2] = w[32]; e_flg[3] = vv; end
    else if (clr) e_flg[3:2] = 2'b00;
  endtask

  task automatic check(input string tag);
    n_vec++;
    if (result_o !== e_res || wr_en_o !== e_we || flags_o !== e_flg || ovf_exc_o !== e_exc) begin
      n_bad++;
      $display("FAIL %s: got res=%h we=%b flg=%b exc=%b exp res=%h we=%b flg=%b exc=%b",
               tag, result_o, wr_en_o, flags_o, ovf_exc_o, e_res, e_we, e_flg, e_exc);
    end
  endtask

  task automatic apply(input logic v, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] imm, input logic zc);
    op_valid_i = v; op_code_i = op; opa_i = a; opb_i = b; imm_i = imm; zclr_i = zc;
    model(v, op, a, b, imm, zc);
    @(posedge clk);
    @(negedge clk);
    check(tag_of(v, op, zc));
  endtask

  function automatic logic [31:0] pick32();
    logic [31:0] pool [6];
    pool[0] = 32'h0; pool[1] = 32'h1; pool[2] = 32'hFFFF_FFFF;
    pool[3] = 32'h7FFF_FFFF; pool[4] = 32'h8000_0000; pool[5] = 32'hFFFF_8000;
    if ($urandom_range(0, 1) == 0) return pool[$urandom_range(0, 5)];
    return $urandom;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(SEED));
    rst_n = 1'b0; op_valid_i = 0; op_code_i = 0; opa_i = 0; opb_i = 0; imm_i = 0; zclr_i = 0;
    e_res = 0; e_we = 0; e_exc = 0; e_flg = 0;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1");

    apply(1, 4'd1, 32'hFFFF_FFFF, 32'h1, 16'h0, 0);
    apply(1, 4'd0, 32'h1234_5678, 32'h0, 16'h0, 0);
    apply(1, 4'd1, 32'h7FFF_FFFF, 32'h1, 16'h0, 0);
    apply(1, 4'd3, 32'h8000_0000, 32'h1, 16'h0, 0);
    apply(1, 4'd3, 32'h0, 32'h1, 16'h0, 0);
    apply(1, 4'd2, 32'h0, 32'h0, 16'h8000, 0);
    apply(1, 4'd4, 32'h0, 32'h0, 16'hFFFF, 0);
    apply(1, 4'd9, 32'hDEAD_BEEF, 32'h0, 16'h8000, 0);
    apply(1, 4'd8, 32'h55, 32'h55, 16'h0, 0);
    apply(0, 4'd1, 32'h1, 32'h1, 16'h0, 1);
    apply(1, 4'd8, 32'h8000_0000, 32'h1, 16'h0, 0);
    apply(1, 4'd5, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 16'h0, 0);
    apply(1, 4'd3, 32'h9, 32'h9, 16'h0, 1);
    apply(1, 4'd0, 32'h0, 32'h0, 16'h0, 1);
    apply(1, 4'd12, 32'h1, 32'h2, 16'h3, 0);
    apply(0, 4'd7, 32'h1, 32'h2, 16'h3, 0);

    for (int i = 0; i < N_RAND; i++) begin
      logic [3:0] op;
      op = ($urandom_range(0, 15) < 13) ? 4'($urandom_range(0, 9)) : 4'($urandom_range(10, 15));
      apply($urandom_range(0, 7) != 0, op, pick32(), pick32(),
            ($urandom_range(0, 1) == 0) ? 16'h8000 : 16'($urandom),
            $urandom_range(0, 5) == 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule